// File: doc/BRIEF.md
# Pattern-Matching Associative Memory

This block is a small content-addressable bank used for track finding. It holds a set of stored patterns, 128 by default. Each pattern is six 12-bit words, one word per detector layer. While the detector is read out, hits arrive on six per-layer buses. Every pattern compares each incoming hit with its own word for that layer, all patterns in parallel. On a match it sets a sticky flag for that layer. A pattern becomes a matched road once the number of flagged layers reaches a programmable threshold.

Matched roads are drained one per handshake, lowest pattern index first. A done flag shows that no unserved road is left. An opcode input, with its address, plane-select and data buses, does four things. It loads pattern words, reads them back, sets the layer threshold, and clears the event state between events.

Top module: `pattern_am`

## Requirements
- R1: With `op_valid` high, opcode 1 writes `wdata` into the word of pattern `addr` on layer `plane`. Opcode 2 puts that word on `rdata`, and `rdata_valid` is high in the following cycle. A `plane` value of 6 or 7 writes nothing, and a read with such a `plane` returns 0.
- R2: A valid hit on layer l sets the layer-l flag of every pattern whose layer-l word equals the hit value. Flags stay set across cycles until the event-clear opcode.
- R3: Hits presented on all six layer buses in the same cycle are all compared and latched in that cycle. Layer l uses `hit_valid[l]` and `hit_data[12*l+11:12*l]`.
- R4: A pattern is a matched road when its count of set layer flags is at least the threshold. After reset the threshold is 6.
- R5: Opcode 3 loads the threshold from `wdata[2:0]` when that value is from 1 to 6. The values 0 and 7 leave the threshold unchanged.
- R6: Opcode 4 clears every layer flag and every served mark. Hits presented in the same cycle as the clear are discarded.
- R7: Unserved matched roads are reported lowest index first. `road_valid` is high and `road_addr` holds the index. A road is served when `road_valid` and `road_ready` are both high at a clock edge. While it is not accepted, and nothing else changes, the address holds.
- R8: `done` is high exactly when no unserved matched road remains.
- R9: After reset, all stored words are 0, no road is reported, `done` is 1 and `rdata_valid` is 0. Opcodes 0 and 5 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 4 | 1 write, 2 read, 3 threshold, 4 event clear |
| addr | input | 7 | Pattern index for read and write |
| plane | input | 3 | Layer word select, 0 to 5 |
| wdata | input | 12 | Write data or threshold value |
| hit_valid | input | 6 | Per-layer hit strobe |
| hit_data | input | 72 | Six 12-bit hit values, layer l at bits 12l and up |
| rdata | output | 12 | Read-back word |
| rdata_valid | output | 1 | Read-back valid, one cycle after a read |
| road_valid | output | 1 | An unserved matched road is presented |
| road_addr | output | 7 | Index of the presented road |
| road_ready | input | 1 | Consumer accepts the presented road |
| done | output | 1 | No unserved matched road remains |

## Verification
Four kinds of hit stimulus are used.

- A full six-layer hit in a single cycle, shared by four patterns with identical words. This separates parallel latching across buses from serial handling, and it checks the lowest-first drain order.
- One layer per cycle on a single pattern. This shows the flags are sticky. It also shows the match appears exactly when the count reaches the threshold, and that rejected threshold values were really ignored.
- A clear issued in the same cycle as a full hit. This separates "clear wins" from "hit wins".
- Random events mixing stored and unrelated hit values under random thresholds. These are compared road by road against a bench model of the flags.

// File: rtl/am_pkg.sv
// Shared definitions for the pattern-matching associative memory.
// Assumes the opcode field is 4 bits wide; unlisted codes are idle.
package am_pkg;
    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_WRITE  = 4'd1,
        OP_READ   = 4'd2,
        OP_THRESH = 4'd3,
        OP_CLEAR  = 4'd4
    } am_op_e;
endpackage

// File: rtl/am_row.sv
// One stored pattern: a word per layer, a comparator per word, a sticky
// hit flag per layer and the layer-count threshold test.
// Assumes clr has priority over hits in the same cycle.
module am_row #(
    parameter int N_LAYER = 6,
    parameter int WORD_W  = 12,
    parameter int SEL_W   = 3,
    parameter int CNT_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_plane,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      clr,
    input  logic [N_LAYER-1:0]        hit_valid,
    input  logic [N_LAYER*WORD_W-1:0] hit_data,
    input  logic [CNT_W-1:0]          thresh,
    output logic [N_LAYER*WORD_W-1:0] words,
    output logic                      match
);
    logic [N_LAYER-1:0] flags;
    logic [CNT_W-1:0]   cnt;

    for (genvar l = 0; l < N_LAYER; l++) begin : g_layer
        logic [WORD_W-1:0] word_q;

        // store the layer word on a write addressed to this row and plane
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && (wr_plane == SEL_W'(l)))
                word_q <= wr_data;
        end

        // latch the sticky flag when this layer's hit equals the word
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                flags[l] <= 1'b0;
            else if (hit_valid[l] && (hit_data[l*WORD_W +: WORD_W] == word_q))
                flags[l] <= 1'b1;
        end

        assign words[l*WORD_W +: WORD_W] = word_q;
    end

    // count flagged layers and test against the threshold
    always_comb begin
        cnt = '0;
        for (int l = 0; l < N_LAYER; l++)
            cnt = cnt + CNT_W'(flags[l]);
        match = (cnt >= thresh);
    end
endmodule

// File: rtl/am_prio.sv
// Priority encoder: reports the lowest set request index.
// Assumes idx is meaningless while any_req is low.
module am_prio #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             any_req,
    output logic [IDX_W-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx     = '0;
        any_req = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx     = IDX_W'(i);
                any_req = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pattern_am.sv
// Pattern bank top: decodes opcodes, fans hits to all rows, keeps the
// threshold and served marks, and drains matched roads lowest first.
// Assumes N_LAYER <= 2**SEL_W and inputs are synchronous to clk.
module pattern_am #(
    parameter int N_PAT   = 128,
    parameter int N_LAYER = 6,
    parameter int WORD_W  = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             op_valid,
    input  logic [3:0]                       op_code,
    input  logic [$clog2(N_PAT)-1:0]         addr,
    input  logic [2:0]                       plane,
    input  logic [WORD_W-1:0]                wdata,
    input  logic [N_LAYER-1:0]               hit_valid,
    input  logic [N_LAYER*WORD_W-1:0]        hit_data,
    output logic [WORD_W-1:0]                rdata,
    output logic                             rdata_valid,
    output logic                             road_valid,
    output logic [$clog2(N_PAT)-1:0]         road_addr,
    input  logic                             road_ready,
    output logic                             done
);
    import am_pkg::*;

    localparam int ADDR_W = $clog2(N_PAT);
    localparam int SEL_W  = 3;
    localparam int CNT_W  = $clog2(N_LAYER + 1);

    logic                      is_wr, is_rd, is_thr, is_clr;
    logic [CNT_W-1:0]          thresh_q;
    logic [N_PAT-1:0]          match, served_q, pending;
    logic [N_LAYER*WORD_W-1:0] row_words [N_PAT];
    logic [WORD_W-1:0]         sel_word;
    logic                      sel_ok;
    logic [CNT_W-1:0]          thr_in;

    // opcode decode
    always_comb begin
        is_wr  = op_valid && (am_op_e'(op_code) == OP_WRITE);
        is_rd  = op_valid && (am_op_e'(op_code) == OP_READ);
        is_thr = op_valid && (am_op_e'(op_code) == OP_THRESH);
        is_clr = op_valid && (am_op_e'(op_code) == OP_CLEAR);
        thr_in = wdata[CNT_W-1:0];
    end

    for (genvar i = 0; i < N_PAT; i++) begin : g_row
        am_row #(
            .N_LAYER (N_LAYER),
            .WORD_W  (WORD_W),
            .SEL_W   (SEL_W),
            .CNT_W   (CNT_W)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (is_wr && (addr == ADDR_W'(i))),
            .wr_plane  (plane),
            .wr_data   (wdata),
            .clr       (is_clr),
            .hit_valid (hit_valid),
            .hit_data  (hit_data),
            .thresh    (thresh_q),
            .words     (row_words[i]),
            .match     (match[i])
        );
    end

    // keep the layer threshold; out-of-range values are rejected
    always_ff @(posedge clk) begin
        if (!rst_n)
            thresh_q <= CNT_W'(N_LAYER);
        else if (is_thr && (thr_in != '0) && (thr_in <= CNT_W'(N_LAYER)))
            thresh_q <= thr_in;
    end

    assign pending = match & ~served_q;

    am_prio #(.N(N_PAT), .IDX_W(ADDR_W)) u_prio (
        .req     (pending),
        .any_req (road_valid),
        .idx     (road_addr)
    );

    // mark roads as served on handshake, forget them on event clear
    always_ff @(posedge clk) begin
        if (!rst_n || is_clr)
            served_q <= '0;
        else if (road_valid && road_ready)
            served_q[road_addr] <= 1'b1;
    end

    // select the addressed layer word for read-back
    always_comb begin
        sel_word = '0;
        sel_ok   = 1'b0;
        for (int l = 0; l < N_LAYER; l++) begin
            if (plane == SEL_W'(l)) begin
                sel_word = row_words[addr][l*WORD_W +: WORD_W];
                sel_ok   = 1'b1;
            end
        end
    end

    // register the read-back word and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= is_rd;
            if (is_rd)
                rdata <= sel_ok ? sel_word : '0;
        end
    end

    assign done = !road_valid;
endmodule

// File: rtl/am_checker.sv
// Temporal checks on the pattern bank ports, bound to every instance.
// Assumes the opcode encoding of am_pkg.
module am_checker #(
    parameter int ADDR_W  = 7,
    parameter int N_LAYER = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [3:0]         op_code,
    input logic [N_LAYER-1:0] hit_valid,
    input logic               rdata_valid,
    input logic               road_valid,
    input logic [ADDR_W-1:0]  road_addr,
    input logic               road_ready,
    input logic               done
);
    logic quiet;
    assign quiet = !(op_valid && (op_code == 4'd3 || op_code == 4'd4)) && (hit_valid == '0);

    // R1: a read yields a valid strobe in the next cycle
    p_read_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd2 |=> rdata_valid);

    // R1: the valid strobe only follows a read
    p_read_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(op_valid && op_code == 4'd2));

    // R6: a clear leaves nothing to report
    p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd4 |=> !road_valid && done);

    // R7: an unaccepted road holds when nothing else changes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        road_valid && !road_ready && quiet |=> road_valid && $stable(road_addr));

    // R7: successive roads come out in increasing index order
    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready && quiet) ##1 road_valid |-> road_addr > $past(road_addr));
endmodule

bind pattern_am am_checker #(.ADDR_W($clog2(N_PAT)), .N_LAYER(N_LAYER)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .hit_valid   (hit_valid),
    .rdata_valid (rdata_valid),
    .road_valid  (road_valid),
    .road_addr   (road_addr),
    .road_ready  (road_ready),
    .done        (done)
);

// File: tb/pattern_am_tb.sv
module pattern_am_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [6:0]  addr = '0;
    logic [2:0]  plane = '0;
    logic [11:0] wdata = '0;
    logic [5:0]  hit_valid = '0;
    logic [71:0] hit_data = '0;
    logic [11:0] rdata;
    logic        rdata_valid;
    logic        road_valid;
    logic [6:0]  road_addr;
    logic        road_ready = 1'b0;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [11:0] mem [128][6];
    logic [5:0]  hb [128];
    bit          srv [128];
    int          thr = 6;

    always #2 clk = ~clk;

    pattern_am u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .addr(addr), .plane(plane), .wdata(wdata), .hit_valid(hit_valid),
        .hit_data(hit_data), .rdata(rdata), .rdata_valid(rdata_valid),
        .road_valid(road_valid), .road_addr(road_addr), .road_ready(road_ready),
        .done(done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic op1(logic [3:0] c, logic [6:0] a, logic [2:0] p, logic [11:0] d);
        op_valid = 1'b1; op_code = c; addr = a; plane = p; wdata = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wr(int p, int l, logic [11:0] d);
        op1(4'd1, 7'(p), 3'(l), d);
        if (l < 6) mem[p][l] = d;
    endtask

    task automatic rd_chk(string req, int p, int l, logic [11:0] exp);
        op1(4'd2, 7'(p), 3'(l), '0);
        chk(req, {31'd0, rdata_valid}, 32'd1);
        chk(req, {20'd0, rdata}, {20'd0, exp});
    endtask

    task automatic clr_ev();
        op1(4'd4, '0, '0, '0);
        for (int p = 0; p < 128; p++) begin hb[p] = '0; srv[p] = 0; end
    endtask

    task automatic set_thr(int t);
        op1(4'd3, '0, '0, 12'(t));
        if (t >= 1 && t <= 6) thr = t;
    endtask

    task automatic hit_cyc(logic [5:0] v, logic [71:0] d);
        hit_valid = v; hit_data = d;
        @(negedge clk);
        hit_valid = '0;
        for (int p = 0; p < 128; p++)
            for (int l = 0; l < 6; l++)
                if (v[l] && mem[p][l] == d[l*12 +: 12]) hb[p][l] = 1'b1;
    endtask

    function automatic logic [71:0] pat_hits(int p);
        logic [71:0] d;
        for (int l = 0; l < 6; l++) d[l*12 +: 12] = mem[p][l];
        return d;
    endfunction

    task automatic drain(string req);
        for (int p = 0; p < 128; p++) begin
            if (!srv[p] && $countones(hb[p]) >= thr) begin
                chk(req, {31'd0, road_valid}, 32'd1);
                chk(req, {25'd0, road_addr}, p);
                road_ready = 1'b1;
                @(negedge clk);
                road_ready = 1'b0;
                srv[p] = 1;
            end
        end
        chk("R8", {31'd0, road_valid}, 32'd0);
        chk("R8", {31'd0, done}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < 128; p++) begin hb[p] = '0; srv[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", {31'd0, road_valid}, 32'd0);
        chk("R9", {31'd0, done}, 32'd1);
        chk("R9", {31'd0, rdata_valid}, 32'd0);
        rd_chk("R9", 17, 2, 12'd0);

        // R1: load the bank with per-pattern distinct words
        for (int p = 0; p < 128; p++)
            for (int l = 0; l < 6; l++)
                wr(p, l, {7'(p), 3'(l), 2'($urandom)});
        for (int l = 0; l < 6; l++) begin
            wr(10, l, mem[3][l]); wr(77, l, mem[3][l]); wr(127, l, mem[3][l]);
        end
        for (int k = 0; k < 20; k++) begin
            int p = int'($urandom % 128);
            int l = int'($urandom % 6);
            rd_chk("R1", p, l, mem[p][l]);
        end
        // R1: plane 6 writes nothing, reads back 0
        op1(4'd1, 7'd5, 3'd6, 12'hABC);
        for (int l = 0; l < 6; l++) rd_chk("R1", 5, l, mem[5][l]);
        rd_chk("R1", 5, 6, 12'd0);
        // R9: unused opcodes do nothing
        op1(4'd9, 7'd5, 3'd0, 12'h123);
        op1(4'd0, 7'd5, 3'd0, 12'h123);
        rd_chk("R9", 5, 0, mem[5][0]);
        chk("R9", {31'd0, road_valid}, 32'd0);

        // R3: all six layers in one cycle, default threshold 6 (R4)
        clr_ev();
        hit_cyc(6'h3F, pat_hits(3));
        chk("R3", {31'd0, road_valid}, 32'd1);
        chk("R7", {25'd0, road_addr}, 32'd3);
        repeat (2) @(negedge clk);
        chk("R7", {25'd0, road_addr}, 32'd3);
        chk("R8", {31'd0, done}, 32'd0);
        drain("R7");

        // R5: threshold 4 accepted, 0 and 7 ignored; R2 sticky per cycle
        clr_ev();
        set_thr(4); set_thr(0); set_thr(7);
        for (int l = 0; l < 3; l++) begin
            logic [71:0] d = '0;
            d[l*12 +: 12] = mem[50][l];
            hit_cyc(6'(1 << l), d);
        end
        chk("R4", {31'd0, road_valid}, 32'd0);
        begin
            logic [71:0] d = '0;
            d[36 +: 12] = mem[50][3];
            hit_cyc(6'h08, d);
        end
        chk("R2", {31'd0, road_valid}, 32'd1);
        chk("R5", {25'd0, road_addr}, 32'd50);
        drain("R5");

        // R6: clear with a full hit in the same cycle
        set_thr(6);
        clr_ev();
        op_valid = 1'b1; op_code = 4'd4;
        hit_valid = 6'h3F; hit_data = pat_hits(60);
        @(negedge clk);
        op_valid = 1'b0; hit_valid = '0;
        chk("R6", {31'd0, road_valid}, 32'd0);
        chk("R6", {31'd0, done}, 32'd1);
        hit_cyc(6'h3F, pat_hits(60));
        chk("R6", {25'd0, road_addr}, 32'd60);
        drain("R6");

        // R2/R4/R7: random events against the model
        for (int ev = 0; ev < 14; ev++) begin
            clr_ev();
            set_thr(int'($urandom % 6) + 1);
            for (int c = 0; c < 8; c++) begin
                logic [71:0] d;
                for (int l = 0; l < 6; l++) begin
                    if ($urandom % 4 == 0) d[l*12 +: 12] = 12'($urandom);
                    else d[l*12 +: 12] = mem[$urandom % 128][l];
                end
                hit_cyc(6'($urandom), d);
            end
            drain("R4");
        end
        summary();
    end
endmodule